// File: doc/BRIEF.md
# Set-Only Event Counter Enable Register

This block holds the enable bits for a small group of event counters. It is a 32-bit control register that software can only set. A write with 1 in some bit positions turns those counters on. A write with 0 in a position leaves that counter as it was. A companion clear-only register, which sits outside this block, turns counters off through a separate clear port. Only the low sixteen bit positions can hold enables. A configuration input gives the number of counters that actually exist, from 1 to 16. Every position at or above that count, and every position in the upper half of the word, reads as zero and cannot be set.

The enables are driven out in parallel so that each counter can gate its increments. A change made by a write or a clear reaches the counters on the cycle after the request.

Each write is checked against the privilege state of the requester, and the result is reported one cycle later:

- **Trap:** a write from level 1 is trapped to level 2 when level 2 is active and its trap control for this register group is set.
- **Permit:** otherwise, a write is accepted only when it comes from the highest implemented level.
- **Undefined:** any other write gets an undefined-instruction result.

Top module: `cnten_set_reg`

## Requirements
- R1: After a cold reset (`rst_n` low), `rd_data`, `cnt_en` and `resp_valid` are all zero.
- R2: When a write is accepted, every bit written as 1 in `wr_data[15:0]` that lies below the configured counter count is 1 in `rd_data` and `cnt_en` on the cycle after the request.
- R3: Bits written as 0 keep their previous value, and no enable falls to 0 unless a clear, a smaller counter count or a reset removes it.
- R4: `rd_data[31:16]` always reads zero, and writes to those positions have no effect.
- R5: With `cfg_num_ctr` = N, `rd_data` bits from N up to 15 read zero and ignore writes. Values of N above 16 act as 16. Lowering N discards the stored enables above the new count.
- R6: When `clr_valid` is high, each enable named by a 1 in `clr_bits` is 0 on the next cycle, unless an accepted write in the same cycle sets that bit. In that case the set wins.
- R7: A write with `cur_level` = 1, `l2_enabled` = 1 and `l2_trap_grp` = 1 leaves the enables unchanged. It responds with `resp_code` = 1 when `l2_wide` = 1 (64-bit hypervisor) or `resp_code` = 2 when `l2_wide` = 0, and with `resp_class` = 0x03.
- R8: A write that is not trapped and has `cur_level` equal to `top_level` is accepted, with `resp_code` = 0 and `resp_class` = 0.
- R9: Any other write leaves the enables unchanged, with `resp_code` = 3 (undefined) and `resp_class` = 0.
- R10: `resp_valid` is 1 exactly in the cycle after a cycle with `wr_valid` high, and 0 otherwise.
- R11: `cnt_en` always equals `rd_data[15:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| cfg_num_ctr | input | 5 | Number of implemented counters |
| cur_level | input | 2 | Privilege level of the current write |
| top_level | input | 2 | Highest implemented privilege level |
| l2_enabled | input | 1 | Level 2 is active |
| l2_wide | input | 1 | Level 2 runs the 64-bit state |
| l2_trap_grp | input | 1 | Level 2 trap control for this register group |
| wr_valid | input | 1 | Write request |
| wr_data | input | 32 | Write data; 1 bits set enables |
| clr_valid | input | 1 | Clear request from the companion register |
| clr_bits | input | 32 | Enables to clear |
| rd_data | output | 32 | Current enables, masked |
| cnt_en | output | 16 | Parallel enables to the counters |
| resp_valid | output | 1 | Write response valid |
| resp_code | output | 2 | 0 permit, 1 wide trap, 2 narrow trap, 3 undefined |
| resp_class | output | 6 | Trap syndrome class (0x03 on trap) |

## Verification
The bench drives several kinds of write pattern and compares each one with the expected result:

- **Set-only behaviour:** sparse single-bit writes followed by all-zero writes separate setting from overwriting.
- **Reserved and unimplemented bits:** writes with every upper bit set, under small and full counter counts, show that those positions are ignored.
- **Clear port:** clears that overlap a same-cycle set show which side wins.
- **Privilege decode:** the privilege inputs are swept through trap, permit and undefined combinations. This tells the two trap forms apart from each other and from a plain refusal.

A long pseudo-random phase that mixes all inputs is then checked on every clock against a behavioural model.

// File: rtl/cnten_pkg.sv
package cnten_pkg;
    localparam int REG_W   = 32;
    localparam int MAX_CTR = 16;
    localparam int CFG_W   = $clog2(MAX_CTR + 1);
    localparam int LVL_W   = 2;
    localparam int EC_W    = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h03;

    typedef enum logic [1:0] {
        RESP_PERMIT    = 2'd0,
        RESP_TRAP_WIDE = 2'd1,
        RESP_TRAP_NARR = 2'd2,
        RESP_UNDEF     = 2'd3
    } resp_e;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic             rsp_vld;
        resp_e            rsp;
        logic [EC_W-1:0]  ec;
    } state_t;
endpackage

// File: rtl/cnten_impl_mask.sv
module cnten_impl_mask #(
    parameter int REG_W   = cnten_pkg::REG_W,
    parameter int MAX_CTR = cnten_pkg::MAX_CTR,
    parameter int CFG_W   = cnten_pkg::CFG_W
) (
    input  logic [CFG_W-1:0] num_ctr,
    output logic [REG_W-1:0] keep
);
    // One mask bit per register position; only the low MAX_CTR can ever be kept.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i < MAX_CTR) begin : g_impl
            assign keep[i] = (int'(num_ctr) > i);
        end else begin : g_resv
            assign keep[i] = 1'b0;
        end
    end
endmodule

// File: rtl/cnten_priv_gate.sv
module cnten_priv_gate #(
    parameter int LVL_W = cnten_pkg::LVL_W
) (
    input  logic             req,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [LVL_W-1:0] top_lvl,
    input  logic             hyp_on,
    input  logic             hyp_wide,
    input  logic             hyp_trap,
    output cnten_pkg::resp_e verdict,
    output logic             commit,
    output logic             trapped
);
    import cnten_pkg::*;

    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

    logic route_hyp;

    always_comb begin
        route_hyp = (cur_lvl == LVL_ONE) && hyp_on && hyp_trap;
        if (route_hyp) begin
            verdict = hyp_wide ? RESP_TRAP_WIDE : RESP_TRAP_NARR;
        end else if (cur_lvl == top_lvl) begin
            verdict = RESP_PERMIT;
        end else begin
            verdict = RESP_UNDEF;
        end
        trapped = route_hyp;
        commit  = req && (verdict == RESP_PERMIT);
    end
endmodule

// File: rtl/cnten_set_reg.sv
module cnten_set_reg
    import cnten_pkg::*;
#(
    parameter int NREG = cnten_pkg::REG_W,
    parameter int NCTR = cnten_pkg::MAX_CTR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       cfg_num_ctr,
    input  logic [1:0]       cur_level,
    input  logic [1:0]       top_level,
    input  logic             l2_enabled,
    input  logic             l2_wide,
    input  logic             l2_trap_grp,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             clr_valid,
    input  logic [31:0]      clr_bits,
    output logic [31:0]      rd_data,
    output logic [15:0]      cnt_en,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [5:0]       resp_class
);
    logic [NREG-1:0] keep;
    resp_e           verdict;
    logic            commit;
    logic            trapped;
    logic [NREG-1:0] set_vec;
    logic [NREG-1:0] clr_vec;
    state_t          st_d, st_q;

    cnten_impl_mask #(.REG_W(NREG), .MAX_CTR(NCTR), .CFG_W(CFG_W)) u_mask (
        .num_ctr (cfg_num_ctr),
        .keep    (keep)
    );

    cnten_priv_gate #(.LVL_W(LVL_W)) u_gate (
        .req      (wr_valid),
        .cur_lvl  (cur_level),
        .top_lvl  (top_level),
        .hyp_on   (l2_enabled),
        .hyp_wide (l2_wide),
        .hyp_trap (l2_trap_grp),
        .verdict  (verdict),
        .commit   (commit),
        .trapped  (trapped)
    );

    always_comb begin
        st_d    = st_q;
        set_vec = commit    ? wr_data  : '0;
        clr_vec = clr_valid ? clr_bits : '0;
        // Clear first, then set, so a same-cycle set wins.
        st_d.en      = ((st_q.en & ~clr_vec) | set_vec) & keep;
        st_d.rsp_vld = wr_valid;
        st_d.rsp     = wr_valid ? verdict : RESP_PERMIT;
        st_d.ec      = (wr_valid && trapped) ? TRAP_EC : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.en & keep;
    assign cnt_en     = rd_data[NCTR-1:0];
    assign resp_valid = st_q.rsp_vld;
    assign resp_code  = st_q.rsp;
    assign resp_class = st_q.ec;
endmodule

// File: rtl/cnten_set_reg_chk.sv
module cnten_set_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  cfg_num_ctr,
    input logic [1:0]  cur_level,
    input logic [1:0]  top_level,
    input logic        l2_enabled,
    input logic        l2_wide,
    input logic        l2_trap_grp,
    input logic        wr_valid,
    input logic        clr_valid,
    input logic [31:0] rd_data,
    input logic [15:0] cnt_en,
    input logic        resp_valid,
    input logic [1:0]  resp_code,
    input logic [5:0]  resp_class
);
    logic hyp_route;
    assign hyp_route = (cur_level == 2'd1) && l2_enabled && l2_trap_grp;

    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> resp_valid);

    // R10
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !resp_valid);

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0);

    // R5
    above_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> cfg_num_ctr) == 32'h0);

    // R3
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_valid |=> (!$stable(cfg_num_ctr) || ((cnt_en & $past(cnt_en)) == $past(cnt_en))));

    // R7
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && hyp_route) |=>
            (resp_class == 6'h03 && resp_code == ($past(l2_wide) ? 2'd1 : 2'd2)));

    // R7
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && hyp_route && !clr_valid) |=> (!$stable(cfg_num_ctr) || $stable(cnt_en)));

    // R8
    permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !hyp_route && cur_level == top_level) |=>
            (resp_code == 2'd0 && resp_class == 6'h00));

    // R9
    undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !hyp_route && cur_level != top_level) |=>
            (resp_code == 2'd3 && resp_class == 6'h00));
endmodule

bind cnten_set_reg cnten_set_reg_chk u_chk (.*);

// File: tb/cnten_set_reg_bench.sv
module cnten_set_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_num_ctr = 5'd8;
    logic [1:0]  cur_level = 2'd3;
    logic [1:0]  top_level = 2'd3;
    logic        l2_enabled = 1'b1;
    logic        l2_wide = 1'b1;
    logic        l2_trap_grp = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic        clr_valid = 1'b0;
    logic [31:0] clr_bits = 32'h0;
    logic [31:0] rd_data;
    logic [15:0] cnt_en;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [5:0]  resp_class;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Behavioural reference state
    logic [15:0] m_en = 16'h0;
    logic        m_rv = 1'b0;
    logic [1:0]  m_rc = 2'd0;
    logic [5:0]  m_ec = 6'd0;

    always #5 clk = ~clk;

    cnten_set_reg u_cnten_set_reg (.*);

    function automatic logic [15:0] lim_mask(input int n);
        logic [15:0] m = 16'h0;
        for (int i = 0; i < 16; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] decide();
        if (cur_level == 2'd1 && l2_enabled && l2_trap_grp) return l2_wide ? 2'd1 : 2'd2;
        if (cur_level == top_level) return 2'd0;
        return 2'd3;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [15:0] e;
        logic [1:0]  v;
        if (!rst_n) begin
            m_en <= 16'h0; m_rv <= 1'b0; m_rc <= 2'd0; m_ec <= 6'd0;
        end else begin
            v = decide();
            e = m_en;
            if (clr_valid) e = e & ~clr_bits[15:0];
            if (wr_valid && v == 2'd0) e = e | wr_data[15:0];
            m_en <= e & lim_mask(int'(cfg_num_ctr));
            m_rv <= wr_valid;
            m_rc <= wr_valid ? v : 2'd0;
            m_ec <= (wr_valid && (v == 2'd1 || v == 2'd2)) ? 6'h03 : 6'h00;
        end
    end

    always @(posedge clk) begin
        #3;
        if (cmp_on) begin
            chk("R4 upper half", {16'h0, rd_data[31:16]}, 32'h0);
            chk("R2 enables", rd_data, {16'h0, m_en & lim_mask(int'(cfg_num_ctr))});
            chk("R11 parallel", {16'h0, cnt_en}, {16'h0, rd_data[15:0]});
            chk("R10 resp_valid", {31'h0, resp_valid}, {31'h0, m_rv});
            if (m_rv) begin
                chk(m_rc == 2'd0 ? "R8 code" : (m_rc == 2'd3 ? "R9 code" : "R7 code"),
                    {30'h0, resp_code}, {30'h0, m_rc});
                chk("R7 class", {26'h0, resp_class}, {26'h0, m_ec});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wr_clr(input logic [31:0] d, input logic [31:0] c);
        wr_valid = 1'b1; wr_data = d; clr_valid = 1'b1; clr_bits = c;
        @(negedge clk);
        wr_valid = 1'b0; clr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 resp_valid", {31'h0, resp_valid}, 32'h0);

        wr(32'h0000_0005);
        chk("R2 set", rd_data, 32'h5);
        chk("R8 permit", {30'h0, resp_code}, 32'h0);
        wr(32'h0);
        chk("R3 zero write", rd_data, 32'h5);
        wr(32'h0000_0002);
        chk("R3 keep bits", rd_data, 32'h7);
        wr(32'hFFFF_FF00);
        chk("R5 above count", rd_data, 32'h7);
        cfg_num_ctr = 5'd16;
        wr(32'hFFFF_8000);
        chk("R4 reserved", rd_data, 32'h8007);

        clr_valid = 1'b1; clr_bits = 32'h3;
        @(negedge clk);
        clr_valid = 1'b0;
        chk("R6 clear", rd_data, 32'h8004);
        wr_clr(32'h4, 32'h8004);
        chk("R6 set wins", rd_data, 32'h4);

        cur_level = 2'd1; l2_trap_grp = 1'b1; l2_wide = 1'b1;
        wr(32'hF0);
        chk("R7 no update", rd_data, 32'h4);
        chk("R7 wide code", {30'h0, resp_code}, 32'h1);
        chk("R7 class", {26'h0, resp_class}, 32'h3);
        l2_wide = 1'b0;
        wr(32'hF0);
        chk("R7 narrow code", {30'h0, resp_code}, 32'h2);

        l2_trap_grp = 1'b0;
        wr(32'hF0);
        chk("R9 undef", {30'h0, resp_code}, 32'h3);
        chk("R9 no update", rd_data, 32'h4);
        l2_enabled = 1'b0; l2_trap_grp = 1'b1;
        wr(32'hF0);
        chk("R9 undef hyp off", {30'h0, resp_code}, 32'h3);

        top_level = 2'd1;
        wr(32'h30);
        chk("R8 top level one", rd_data, 32'h34);
        chk("R8 code", {30'h0, resp_code}, 32'h0);

        top_level = 2'd3; cur_level = 2'd3; l2_enabled = 1'b1; l2_trap_grp = 1'b0;
        wr(32'hF0);
        chk("R2 more bits", rd_data, 32'hF4);
        cfg_num_ctr = 5'd4;
        @(negedge clk);
        chk("R5 shrink", rd_data, 32'h4);
        chk("R11 cnt_en", {16'h0, cnt_en}, 32'h4);
        cfg_num_ctr = 5'd20;
        @(negedge clk);
        chk("R5 discarded", rd_data, 32'h4);
        chk("R10 idle", {31'h0, resp_valid}, 32'h0);

        for (int k = 0; k < 600; k++) begin
            wr_valid    = $urandom_range(0, 1) == 1;
            wr_data     = $urandom;
            clr_valid   = $urandom_range(0, 4) == 0;
            clr_bits    = $urandom;
            cur_level   = 2'($urandom_range(0, 3));
            top_level   = ($urandom_range(0, 3) == 0) ? 2'd2 : 2'd3;
            l2_enabled  = $urandom_range(0, 1) == 1;
            l2_wide     = $urandom_range(0, 1) == 1;
            l2_trap_grp = $urandom_range(0, 2) == 0;
            if ($urandom_range(0, 15) == 0) cfg_num_ctr = 5'($urandom_range(0, 20));
            @(negedge clk);
        end
        wr_valid = 1'b0; clr_valid = 1'b0;
        @(negedge clk);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cold reset", rd_data, 32'h0);
        chk("R1 cnt_en", {16'h0, cnt_en}, 32'h0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule